// File: doc/BRIEF.md
# Fracturable Lookup Table Element

This block is a configurable function generator built around a 64-entry truth table. Once the table has been loaded it evaluates, with no clock, any Boolean function of six select inputs. It can also be split into two independent functions of the five low select inputs, and each of those has its own output.

The table is loaded serially. While the load enable is high, one bit enters on each clock edge and the first bit sent ends up as the highest entry. A mode bit is captured during the same load and reported on a status pin. A ready flag shows that a complete 64-bit load has finished.

Both function outputs are available directly. They also have registered copies that update under a clock enable, so a downstream stage can take either form.

Top module: `frac_lut`

## Requirements
- R1: During and right after reset, `tbl_ready`, `split_mode`, `f_main`, `f_aux`, `f_main_q` and `f_aux_q` are all 0, because the table is cleared to all zeros.
- R2: On each rising clock edge with `cfg_en` high, the table shifts up by one entry and `cfg_bit` enters at entry 0. After 64 such edges, the first bit sent sits at entry 63 and the last bit sent sits at entry 0.
- R3: While `cfg_en` is low, the table and the mode bit do not change, whatever `cfg_bit` and `cfg_split` do.
- R4: `tbl_ready` is 1 only while `cfg_en` is low and the most recent burst of `cfg_en` contained at least 64 edges. Starting a new burst clears it, and a burst shorter than 64 edges leaves it at 0.
- R5: On each edge with `cfg_en` high, `cfg_split` is captured as the mode bit, which `split_mode` reports (0 = one 6-input function, 1 = two 5-input functions).
- R6: In full mode, `f_main` equals table entry `sel`, with `sel[5]` as the most significant index bit.
- R7: In split mode, `f_main` equals table entry {1, `sel[4:0]`}, and `sel[5]` has no effect on any output.
- R8: In both modes, `f_aux` equals table entry {0, `sel[4:0]`}.
- R9: On a clock edge with `reg_ce` high, `f_main_q` and `f_aux_q` capture the values `f_main` and `f_aux` had just before the edge. Without `reg_ce` they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading and for the output registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Load enable; shifts one table bit per edge |
| cfg_bit | input | 1 | Serial table data, highest entry first |
| cfg_split | input | 1 | Mode bit captured during a load (1 = split) |
| sel | input | 6 | Function select inputs |
| reg_ce | input | 1 | Clock enable of the registered outputs |
| f_main | output | 1 | Combinational 6-input (or upper 5-input) function |
| f_aux | output | 1 | Combinational lower-half 5-input function |
| f_main_q | output | 1 | Registered copy of f_main |
| f_aux_q | output | 1 | Registered copy of f_aux |
| split_mode | output | 1 | Active mode: 0 full, 1 split |
| tbl_ready | output | 1 | A complete 64-bit load has finished |

## Verification
The output registers can capture on the same edge that shifts a new table bit in. The capture must then take the function values from the table as it was before the edge. The bench provokes this by asserting `reg_ce` and `cfg_en` together on one edge with a known table and select value. It then checks that the registered outputs hold the old entry, that the combinational outputs already reflect the shifted table, and that `tbl_ready` has dropped because a new burst has begun.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/frac_lut_cfg.sv
module frac_lut_cfg
  import frac_lut_pkg::*;
#(
  parameter int K = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_bit,
  input  logic                cfg_split,
  output logic [(1<<K)-1:0]   tbl,
  output lut_mode_e           mode,
  output logic                ready
);
  localparam int TBL = 1 << K;
  localparam int CW  = $clog2(TBL + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(TBL);

  logic          en_q;
  logic [CW-1:0] cnt;
  logic          burst_start;

  assign burst_start = cfg_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl  <= '0;
      mode <= MODE_FULL;
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= cfg_en;
      if (cfg_en) begin
        tbl  <= {tbl[TBL-2:0], cfg_bit};
        mode <= lut_mode_e'(cfg_split);
        if (burst_start)          cnt <= CW'(1);
        else if (cnt != FULL_CNT) cnt <= cnt + CW'(1);
      end
    end
  end

  assign ready = !cfg_en && (cnt == FULL_CNT);

  // R2: the new bit lands at entry 0, older entries move up
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (tbl[0] == $past(cfg_bit)) && (tbl[TBL-1:1] == $past(tbl[TBL-2:0])));
  // R3: no load, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(tbl) && $stable(mode));
  // R4: ready can only appear as a burst ends
  p_ready_after_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cfg_en));
  // R5: mode follows the captured bit
  p_mode_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (mode == lut_mode_e'($past(cfg_split))));
endmodule

// File: rtl/frac_lut_read.sv
module frac_lut_read
  import frac_lut_pkg::*;
#(
  parameter int K = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [(1<<K)-1:0] tbl,
  input  lut_mode_e         mode,
  input  logic [K-1:0]      sel,
  output logic              f_main,
  output logic              f_aux
);
  // Main output index: in split mode the top index bit is forced to 1.
  function automatic logic [K-1:0] main_index(lut_mode_e m, logic [K-1:0] s);
    return {(m == MODE_SPLIT) ? 1'b1 : s[K-1], s[K-2:0]};
  endfunction

  // Auxiliary output index: always the lower half.
  function automatic logic [K-1:0] aux_index(logic [K-1:0] s);
    return {1'b0, s[K-2:0]};
  endfunction

  logic [K-1:0] idx_main;
  logic [K-1:0] idx_aux;

  assign idx_main = main_index(mode, sel);
  assign idx_aux  = aux_index(sel);
  assign f_main   = tbl[idx_main];
  assign f_aux    = tbl[idx_aux];

  // R7: in split mode the top select bit must not move the main output
  p_split_top_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SPLIT) && $stable(mode) && $stable(tbl) && $stable(sel[K-2:0]))
      |-> $stable(f_main));
  // R8: the aux output ignores the top select bit in every mode
  p_aux_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(tbl) && $stable(sel[K-2:0])) |-> $stable(f_aux));
endmodule

// File: rtl/frac_lut_oreg.sv
module frac_lut_oreg (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic d_main,
  input  logic d_aux,
  output logic q_main,
  output logic q_aux
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_main <= 1'b0;
      q_aux  <= 1'b0;
    end else if (ce) begin
      q_main <= d_main;
      q_aux  <= d_aux;
    end
  end

  // R9: capture on enable, hold otherwise
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q_main == $past(d_main)) && (q_aux == $past(d_aux)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q_main) && $stable(q_aux));
endmodule

// File: rtl/frac_lut.sv
module frac_lut
  import frac_lut_pkg::*;
#(
  parameter int K = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         cfg_split,
  input  logic [K-1:0] sel,
  input  logic         reg_ce,
  output logic         f_main,
  output logic         f_aux,
  output logic         f_main_q,
  output logic         f_aux_q,
  output logic         split_mode,
  output logic         tbl_ready
);
  localparam int TBL = 1 << K;

  logic [TBL-1:0] tbl;
  lut_mode_e      mode;

  frac_lut_cfg #(.K(K)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_split(cfg_split), .tbl(tbl), .mode(mode), .ready(tbl_ready)
  );

  frac_lut_read #(.K(K)) u_read (
    .clk(clk), .rst_n(rst_n), .tbl(tbl), .mode(mode), .sel(sel),
    .f_main(f_main), .f_aux(f_aux)
  );

  frac_lut_oreg u_oreg (
    .clk(clk), .rst_n(rst_n), .ce(reg_ce), .d_main(f_main), .d_aux(f_aux),
    .q_main(f_main_q), .q_aux(f_aux_q)
  );

  assign split_mode = (mode == MODE_SPLIT);
endmodule

// File: tb/frac_lut_bench.sv
`timescale 1ns/1ps
module frac_lut_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_split = 1'b0, reg_ce = 1'b0;
  logic [5:0] sel = '0;
  logic f_main, f_aux, f_main_q, f_aux_q, split_mode, tbl_ready;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  frac_lut u_frac_lut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_split(cfg_split), .sel(sel), .reg_ce(reg_ce), .f_main(f_main),
    .f_aux(f_aux), .f_main_q(f_main_q), .f_aux_q(f_aux_q),
    .split_mode(split_mode), .tbl_ready(tbl_ready)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (sel=%0d)", req, act, exp, sel);
    end
  endtask

  // Shift n bits of t, highest first, then drop cfg_en.
  task automatic load(logic [63:0] t, logic split, int n);
    for (int i = 63; i > 63 - n; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_bit = t[i]; cfg_split = split;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    #1;
    check("R1 ready", tbl_ready, 1'b0);
    check("R1 split", split_mode, 1'b0);
    check("R1 main", f_main, 1'b0);
    check("R1 aux", f_aux, 1'b0);
    check("R1 main_q", f_main_q, 1'b0);
    check("R1 aux_q", f_aux_q, 1'b0);
  endtask

  task automatic test_order();
    logic [63:0] t = 64'h8000_0000_0000_0001;
    load(t, 1'b0, 64);
    sel = 6'd63; #1; check("R2 entry63", f_main, 1'b1);
    sel = 6'd0;  #1; check("R2 entry0", f_main, 1'b1);
    sel = 6'd62; #1; check("R2 entry62", f_main, 1'b0);
  endtask

  task automatic test_full(logic [63:0] t);
    load(t, 1'b0, 64);
    check("R4 ready after load", tbl_ready, 1'b1);
    check("R5 full mode", split_mode, 1'b0);
    for (int s = 0; s < 64; s++) begin
      sel = 6'(s); #1;
      check("R6 full main", f_main, t[s]);
      check("R8 aux full", f_aux, t[{1'b0, sel[4:0]}]);
    end
  endtask

  task automatic test_split(logic [63:0] t);
    load(t, 1'b1, 64);
    check("R5 split mode", split_mode, 1'b1);
    for (int s = 0; s < 64; s++) begin
      sel = 6'(s); #1;
      check("R7 split main", f_main, t[{1'b1, sel[4:0]}]);
      check("R8 aux split", f_aux, t[{1'b0, sel[4:0]}]);
    end
  endtask

  task automatic test_hold(logic [63:0] t);
    load(t, 1'b1, 64);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit; cfg_split = ~cfg_split;
    end
    #1;
    check("R3 mode held", split_mode, 1'b1);
    check("R4 ready held", tbl_ready, 1'b1);
    for (int s = 0; s < 32; s++) begin
      sel = 6'(s); #1;
      check("R3 table held", f_aux, t[s]);
    end
  endtask

  task automatic test_short(logic [63:0] t);
    load(t, 1'b0, 40);
    check("R4 short burst not ready", tbl_ready, 1'b0);
    load(t, 1'b0, 64);
    check("R4 full burst ready", tbl_ready, 1'b1);
  endtask

  task automatic test_reg(logic [63:0] t);
    logic em, ea;
    load(t, 1'b0, 64);
    sel = 6'd45; #1;
    em = t[45]; ea = t[13];
    reg_ce = 1'b1;
    @(negedge clk); reg_ce = 1'b0; #1;
    check("R9 capture main", f_main_q, em);
    check("R9 capture aux", f_aux_q, ea);
    sel = 6'd18;
    @(negedge clk); #1;
    check("R9 hold main", f_main_q, em);
    check("R9 hold aux", f_aux_q, ea);
  endtask

  task automatic test_overlap(logic [63:0] t);
    logic [63:0] nt;
    load(t, 1'b0, 64);
    sel = 6'd50; #1;
    nt = {t[62:0], ~t[0]};
    @(negedge clk);
    cfg_en = 1'b1; cfg_bit = ~t[0]; reg_ce = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0; reg_ce = 1'b0; #1;
    check("R9 overlap old main", f_main_q, t[50]);
    check("R9 overlap old aux", f_aux_q, t[18]);
    check("R2 overlap new main", f_main, nt[50]);
    check("R4 overlap ready cleared", tbl_ready, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_order();
    for (int r = 0; r < 3; r++) begin
      t = {$urandom, $urandom};
      test_full(t);
      test_split(t ^ 64'hF0F0_0F0F_3C3C_A5A5);
    end
    test_hold({$urandom, $urandom});
    test_short({$urandom, $urandom});
    test_reg(64'h0000_2000_0000_2000);
    test_overlap({$urandom, $urandom});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule